// File: doc/BRIEF.md
# Bit-Scan and Zero-Count Unit

This execution unit resolves one shared instruction encoding into either a count of zero bits or an index-of-set-bit scan, over a 32-bit or 64-bit operand. A scan-direction select chooses the end of the operand: reverse works from the most significant bit, forward from the least significant bit. A repeat-prefix flag together with a count-feature strap decides which meaning applies. With both set, the unit counts leading or trailing zeros. Otherwise it runs the older scan, which returns the position of the highest or lowest set bit.

The two meanings handle an all-zero operand differently and set their flags by different rules. Count mode reports the operand width for a zero operand and raises the carry flag. Scan mode raises the zero flag and passes the incoming destination value through unchanged, so its zero-operand result is deterministic. The result and both flags are computed combinationally and registered once. The valid output follows a request by exactly one cycle.

Top module: `bscnt_unit`

## Requirements
- R1: With `rep_pfx`=1 and `cnt_en`=1, `op_rev`=1 returns the count of leading zero bits and `op_rev`=0 returns the count of trailing zero bits of the operand.
- R2: With `cnt_en`=0 the value of `rep_pfx` has no effect, and scan mode runs. With `cnt_en`=1 and `rep_pfx`=0, scan mode also runs.
- R3: In count mode a zero operand returns the operand width (32 or 64), with `res_cf`=1 and `res_zf`=0.
- R4: In scan mode a zero operand returns `dst_in` unchanged, with `res_zf`=1 and `res_cf`=0.
- R5: In count mode with a non-zero operand, `res_cf`=0, and `res_zf`=1 exactly when the count is zero. An all-ones operand gives 0 with `res_zf`=1.
- R6: In scan mode `op_rev`=1 returns the bit position (0 = least significant) of the highest set bit, with `res_zf`=0 and `res_cf`=0.
- R7: In scan mode `op_rev`=0 returns the bit position of the lowest set bit, with `res_zf`=0 and `res_cf`=0.
- R8: With `size64`=0 only bits 31:0 of `src` form the operand, and bits above are ignored. With `size64`=1 all 64 bits form the operand and counts range up to 64. Results are zero-extended to the data width.
- R9: `res_valid` is high in the cycle after `req_valid` was sampled high, and low otherwise. Without a request, `res_data`, `res_cf` and `res_zf` hold their values.
- R10: Synchronous active-high reset clears `res_valid`, `res_data`, `res_cf` and `res_zf` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request, sampled on the rising edge |
| src | input | DW | Source operand |
| size64 | input | 1 | 1 = full-width operand, 0 = low half only |
| dst_in | input | DW | Current destination value |
| op_rev | input | 1 | 1 = reverse (from MSB), 0 = forward (from LSB) |
| rep_pfx | input | 1 | Repeat prefix present |
| cnt_en | input | 1 | Count-feature strap |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_data | output | DW | Destination result |
| res_cf | output | 1 | Carry flag |
| res_zf | output | 1 | Zero flag |

## Verification
The assertions assume that every control and data input is a defined 0 or 1 in each cycle where `req_valid` is high. They also assume that the upper half of `src` may hold any value when `size64` is 0. They read the result one edge after the request and treat that edge's request inputs as the only cause of the outputs. The stimulus sets every input on the falling edge, raises `req_valid` for single cycles or back-to-back runs, and never leaves an input undriven. It deliberately places non-zero bits above bit 31 in half-width operations, so that the masking is exercised rather than assumed.

// File: rtl/bscnt_pkg.sv
package bscnt_pkg;

  typedef enum logic {
    SCAN_FWD = 1'b0,
    SCAN_REV = 1'b1
  } scan_dir_e;

  typedef enum logic {
    SEM_LEGACY = 1'b0,
    SEM_COUNT  = 1'b1
  } sem_e;

  // Count semantics need both the prefix and the feature strap.
  function automatic sem_e pick_sem(input logic rep, input logic feat);
    return (rep && feat) ? SEM_COUNT : SEM_LEGACY;
  endfunction

endpackage

// File: rtl/bscnt_prienc.sv
module bscnt_prienc #(
  parameter int  W        = 64,
  parameter bit  FROM_MSB = 1'b1,
  localparam int IW       = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          hit
);

  assign hit = |vec;

  generate
    if (FROM_MSB) begin : g_msb
      // Ascending walk: the last set bit seen is the highest one.
      always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
          if (vec[i]) idx = IW'(i);
        end
      end
    end else begin : g_lsb
      // Descending walk: the last set bit seen is the lowest one.
      always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
          if (vec[i]) idx = IW'(i);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bscnt_core.sv
module bscnt_core
  import bscnt_pkg::*;
#(
  parameter int  DW = 64,
  localparam int IW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input  logic [DW-1:0] src,
  input  logic          size64,
  input  logic [DW-1:0] dst_in,
  input  logic          op_rev,
  input  logic          rep_pfx,
  input  logic          cnt_en,
  output logic [DW-1:0] data,
  output logic          cf,
  output logic          zf
);

  logic [DW-1:0] opnd;
  logic [DW-1:0] width_v;
  logic [IW-1:0] hi_idx, lo_idx;
  logic          hi_hit, lo_hit;
  sem_e          sem;
  scan_dir_e     dir;

  // Half-width operations see only the low half of the source.
  assign opnd    = size64 ? src : {{HW{1'b0}}, src[HW-1:0]};
  assign width_v = size64 ? DW'(DW) : DW'(HW);
  assign sem     = pick_sem(rep_pfx, cnt_en);
  assign dir     = scan_dir_e'(op_rev);

  bscnt_prienc #(.W(DW), .FROM_MSB(1'b1)) u_hi (
    .vec(opnd), .idx(hi_idx), .hit(hi_hit)
  );

  bscnt_prienc #(.W(DW), .FROM_MSB(1'b0)) u_lo (
    .vec(opnd), .idx(lo_idx), .hit(lo_hit)
  );

  logic [DW-1:0] sel_idx;
  logic [DW-1:0] cnt_val;

  always_comb begin
    sel_idx = (dir == SCAN_REV) ? DW'(hi_idx) : DW'(lo_idx);
    // Leading zeros = width - 1 - highest index; trailing zeros = lowest index.
    cnt_val = (dir == SCAN_REV) ? (width_v - DW'(1) - DW'(hi_idx)) : DW'(lo_idx);
  end

  always_comb begin
    if (sem == SEM_COUNT) begin
      if (!hi_hit) begin
        data = width_v;
        cf   = 1'b1;
        zf   = 1'b0;
      end else begin
        data = cnt_val;
        cf   = 1'b0;
        zf   = (cnt_val == '0);
      end
    end else begin
      if (!lo_hit) begin
        data = dst_in;
        cf   = 1'b0;
        zf   = 1'b1;
      end else begin
        data = sel_idx;
        cf   = 1'b0;
        zf   = 1'b0;
      end
    end
  end

endmodule

// File: rtl/bscnt_unit.sv
module bscnt_unit #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [DW-1:0] src,
  input  logic          size64,
  input  logic [DW-1:0] dst_in,
  input  logic          op_rev,
  input  logic          rep_pfx,
  input  logic          cnt_en,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          res_cf,
  output logic          res_zf
);

  logic [DW-1:0] nx_data;
  logic          nx_cf, nx_zf;

  bscnt_core #(.DW(DW)) u_core (
    .src    (src),
    .size64 (size64),
    .dst_in (dst_in),
    .op_rev (op_rev),
    .rep_pfx(rep_pfx),
    .cnt_en (cnt_en),
    .data   (nx_data),
    .cf     (nx_cf),
    .zf     (nx_zf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_cf    <= 1'b0;
      res_zf    <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_data <= nx_data;
        res_cf   <= nx_cf;
        res_zf   <= nx_zf;
      end
    end
  end

endmodule

// File: rtl/bscnt_chk.sv
module bscnt_chk #(
  parameter int  DW = 64,
  localparam int IW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [DW-1:0] src,
  input logic          size64,
  input logic [DW-1:0] dst_in,
  input logic          op_rev,
  input logic          rep_pfx,
  input logic          cnt_en,
  input logic          res_valid,
  input logic [DW-1:0] res_data,
  input logic          res_cf,
  input logic          res_zf
);

  logic          in_zero;
  logic          in_cnt;
  logic [DW-1:0] src_q;

  assign in_zero = size64 ? (src == '0) : (src[HW-1:0] == '0);
  assign in_cnt  = rep_pfx && cnt_en;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else if (req_valid) src_q <= src;
  end

  // R9
  p_lat_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!res_valid && $stable(res_data) && $stable(res_cf) && $stable(res_zf)));

  p_cnt_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_cnt && in_zero) |=>
      (res_cf && !res_zf && res_data == ($past(size64) ? DW'(DW) : DW'(HW))));

  p_leg_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_cnt && in_zero) |=>
      (res_zf && !res_cf && res_data == $past(dst_in)));

  p_cnt_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_cnt && !in_zero) |=>
      (!res_cf && (res_zf == (res_data == '0))));

  // R6 and R7: a scan result names a bit that was set in the operand.
  p_leg_bit_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_cnt && !in_zero) |=>
      (!res_zf && !res_cf && src_q[res_data[IW-1:0]] && (res_data < DW'(DW))));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0 && !res_cf && !res_zf));

endmodule

bind bscnt_unit bscnt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .src(src), .size64(size64),
  .dst_in(dst_in), .op_rev(op_rev), .rep_pfx(rep_pfx), .cnt_en(cnt_en),
  .res_valid(res_valid), .res_data(res_data), .res_cf(res_cf), .res_zf(res_zf)
);

// File: tb/sim_bscnt_unit.sv
`timescale 1ns/1ps
module sim_bscnt_unit;

  localparam int DW = 64;
  localparam int NV = 17;

  typedef struct packed {
    logic [63:0] src;
    logic        sz64;
    logic        rev;
    logic        rep;
    logic        cen;
    logic [63:0] dst;
    logic [63:0] exp;
    logic        cf;
    logic        zf;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] DSTV = 64'hDEAD_BEEF_1234_5678;

  localparam vec_t VEC [NV] = '{
    // src                  sz rev rep cen dst    exp     cf zf req
    '{64'h0000_0000_0000_E000, 0, 1, 1, 1, DSTV, 64'd16, 0, 0, 8'd1}, // R1 lzcnt
    '{64'h0000_0000_0000_E000, 0, 0, 1, 1, DSTV, 64'd13, 0, 0, 8'd1}, // R1 tzcnt
    '{64'h0000_0000_FFFF_FFFF, 0, 1, 1, 1, DSTV, 64'd0,  0, 1, 8'd5}, // R5
    '{64'h0000_0000_FFFF_FFFF, 0, 0, 1, 1, DSTV, 64'd0,  0, 1, 8'd5}, // R5
    '{64'h0,                   0, 1, 1, 1, DSTV, 64'd32, 1, 0, 8'd3}, // R3
    '{64'h0,                   1, 0, 1, 1, DSTV, 64'd64, 1, 0, 8'd3}, // R3
    '{64'h0000_0000_FFFF_FFFF, 0, 1, 0, 1, DSTV, 64'd31, 0, 0, 8'd6}, // R6
    '{64'h0000_0000_0000_E000, 0, 0, 1, 0, DSTV, 64'd13, 0, 0, 8'd2}, // R2
    '{64'h0000_0000_0000_E000, 0, 1, 1, 0, DSTV, 64'd15, 0, 0, 8'd2}, // R2
    '{64'h0,                   0, 0, 0, 1, DSTV, DSTV,   0, 1, 8'd4}, // R4
    '{64'h8000_0000_0000_0001, 1, 1, 0, 0, DSTV, 64'd63, 0, 0, 8'd6}, // R6
    '{64'h8000_0000_0000_0001, 1, 0, 0, 0, DSTV, 64'd0,  0, 0, 8'd7}, // R7
    '{64'h0000_0000_0000_0001, 1, 1, 1, 1, DSTV, 64'd63, 0, 0, 8'd8}, // R8
    '{64'hFFFF_FFFF_0000_0000, 0, 1, 1, 1, DSTV, 64'd32, 1, 0, 8'd8}, // R8
    '{64'h0000_0001_0000_0010, 0, 1, 0, 0, DSTV, 64'd4,  0, 0, 8'd8}, // R8
    '{64'h8000_0000_0000_0000, 1, 0, 1, 1, DSTV, 64'd63, 0, 0, 8'd1}, // R1
    '{64'h0000_0000_8000_0000, 0, 0, 0, 0, DSTV, 64'd31, 0, 0, 8'd7}  // R7
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [DW-1:0] src = '0;
  logic          size64 = 1'b0;
  logic [DW-1:0] dst_in = '0;
  logic          op_rev = 1'b0;
  logic          rep_pfx = 1'b0;
  logic          cnt_en = 1'b0;
  logic          res_valid;
  logic [DW-1:0] res_data;
  logic          res_cf;
  logic          res_zf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bscnt_unit #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .src(src), .size64(size64),
    .dst_in(dst_in), .op_rev(op_rev), .rep_pfx(rep_pfx), .cnt_en(cnt_en),
    .res_valid(res_valid), .res_data(res_data), .res_cf(res_cf), .res_zf(res_zf)
  );

  task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    src = v.src; size64 = v.sz64; op_rev = v.rev;
    rep_pfx = v.rep; cnt_en = v.cen; dst_in = v.dst;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", {res_valid, res_data, res_cf, res_zf}, 67'd0);
    rst = 1'b0;

    // Vector table: request on one edge, result read at the next falling edge.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R%0d vec%0d", VEC[i].req, i),
            {res_valid, res_data, res_cf, res_zf},
            {1'b1, VEC[i].exp, VEC[i].cf, VEC[i].zf});
    end

    // R9: idle cycles drop valid and hold the previous result.
    src = 64'h5; op_rev = 1'b1; rep_pfx = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    check("R9 idle hold", {res_valid, res_data, res_cf, res_zf},
          {1'b0, 64'd31, 1'b0, 1'b0});
    @(negedge clk);
    check("R9 idle hold2", {res_valid, res_data, res_cf, res_zf},
          {1'b0, 64'd31, 1'b0, 1'b0});

    // R9 back-to-back requests: each result appears one cycle later.
    @(negedge clk);
    drive(VEC[0]); req_valid = 1'b1;
    @(negedge clk);
    check("R9 b2b first", {res_valid, res_data, res_cf, res_zf},
          {1'b1, 64'd16, 1'b0, 1'b0});
    drive(VEC[5]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 b2b second", {res_valid, res_data, res_cf, res_zf},
          {1'b1, 64'd64, 1'b1, 1'b0});

    // R2: rep_pfx ignored with cnt_en=0 on a zero operand (scan zero result).
    drive(VEC[9]); rep_pfx = 1'b1; cnt_en = 1'b0; dst_in = 64'h0123_4567_89AB_CDEF;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 rep ignored zero", {res_valid, res_data, res_cf, res_zf},
          {1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1});

    // R10: reset in the middle clears the outputs.
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid reset", {res_valid, res_data, res_cf, res_zf}, 67'd0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule